// File: doc/BRIEF.md
# Three-Wire Serial Register Port

This block is the slave side of a three-wire serial control link: an enable line, a serial clock and one bidirectional data line. A host controller uses it to program a bank of 8-bit control registers and to read them back, including a fixed read-only identification register. Every frame opens with an 8-bit address sent least-significant bit first. The top address bit picks the direction (0 means write, 1 means read). Address bits 5..0 pick the register, and bit 6 has no meaning.

In a write frame the host sends at least eight data bits after the address. The last eight bits shifted in before the enable falls are copied into the addressed register at the moment the enable falls. In a read frame the addressed register is captured as soon as the read bit arrives. The host then gives two wait clocks, and the block returns the byte least-significant bit first, one bit on each falling serial clock edge. The three serial inputs are oversampled in a faster system clock through two-flop synchronizers.

The bank holds the writable registers at addresses 0 to NUM_REGS-1 (eleven by default: configuration, power control, head select, MR current DAC, write current DAC, servo write, test mode, compensation capacitors, HF attenuator, HF boost and settle time). It also holds the identification register at address ID_ADDR (15). The register contents are presented in parallel for the analog decoders.

Top module: `serial_reg_port`

## Requirements
- R1: After reset every writable register reads 0 and the data output enable is low.
- R2: A write frame (address bit 7 = 0) of 8 address bits and 8 data bits, each field least-significant bit first, stores the data in the register selected by address bits 5..0. Address bit 6 has no effect on the selection.
- R3: A write frame in which the enable falls before 16 bits have arrived leaves every register unchanged.
- R4: When a write frame carries more than 16 bits, the register receives the last 8 bits received before the enable fell.
- R5: Serial clock edges and data while the enable is low are ignored. They neither change registers nor leave partial bits in the next frame.
- R6: In a read frame (address bit 7 = 1) the data line stays undriven through the two wait rising edges. Bit d0 of the addressed register is driven from the first falling edge after them, and each further bit follows on each later falling edge.
- R7: When the enable falls during a read, driving stops at once and no register changes.
- R8: Address 15 reads as 0x03 and ignores writes. An address with no register reads as 0x00 and ignores writes.
- R9: Register contents change only in the system cycle in which the falling enable is detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Active-low reset, clears all registers |
| sclk | input | 1 | Serial clock from the host |
| sen | input | 1 | Serial frame enable, high during a frame |
| sdio_in | input | 1 | Serial data line as seen at the pad |
| sdio_out | output | 1 | Serial data driven during read data |
| sdio_oe | output | 1 | Output enable for the data pad |
| regs_flat | output | NUM_REGS*8 | Writable registers, register i at bits i*8+7..i*8 |

## Verification
The embedded properties check on every cycle that registers move only when a falling enable is seen, that the data pad is released after the enable drops, and that the driver turns on only at a serial clock falling edge. They also check that the driven bit holds steady between falling edges. What they cannot see is whether the right value reached the right register, which needs the bench's scenarios: bit order, the ignored address bit, overrun keeping the last byte, short frames, aborted reads, and the identification and unmapped addresses. The two-cycle wait before read data and its alignment to the serial clock are also shown only by those scenarios.

// File: rtl/serial_reg_port.sv
module serial_reg_port #(
  parameter int NUM_REGS = 11,
  parameter int ID_ADDR  = 15,
  parameter logic [7:0] ID_VALUE = 8'h03
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sclk,
  input  logic                  sen,
  input  logic                  sdio_in,
  output logic                  sdio_out,
  output logic                  sdio_oe,
  output logic [NUM_REGS*8-1:0] regs_flat
);
  localparam int W    = 8;
  localparam int CNTW = $clog2(2*W+1);
  localparam logic [CNTW-1:0] FULL = CNTW'(2*W);

  logic [2:0] sclk_sy, sen_sy;
  logic [1:0] sdi_sy;
  logic [CNTW-1:0] cnt;
  logic [W-1:0] addr_q, data_q, tx_q, rd_val;
  logic [1:0] waits;
  logic [3:0] sent;
  logic rd_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_sy <= '0; sen_sy <= '0; sdi_sy <= '0;
    end else begin
      sclk_sy <= {sclk_sy[1:0], sclk};
      sen_sy  <= {sen_sy[1:0], sen};
      sdi_sy  <= {sdi_sy[0], sdio_in};
    end

  wire sen_s      = sen_sy[1];
  wire sen_fall   = sen_sy[2] & ~sen_sy[1];
  wire sclk_rise  = sclk_sy[1] & ~sclk_sy[2];
  wire sclk_fall  = sclk_sy[2] & ~sclk_sy[1];
  wire sdi        = sdi_sy[1];
  wire [W-1:0] addr_next = {sdi, addr_q[W-1:1]};
  wire commit     = sen_fall && cnt == FULL && !addr_q[W-1];

  always_comb begin
    rd_val = '0;
    if (addr_next[5:0] == 6'(ID_ADDR)) rd_val = ID_VALUE;
    for (int i = 0; i < NUM_REGS; i++)
      if (addr_next[5:0] == 6'(i)) rd_val = regs_flat[i*W +: W];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt <= '0; addr_q <= '0; data_q <= '0; tx_q <= '0;
      rd_q <= 1'b0; waits <= '0; sent <= '0;
      sdio_out <= 1'b0; sdio_oe <= 1'b0;
    end else if (!sen_s) begin
      cnt <= '0; rd_q <= 1'b0; waits <= '0; sent <= '0; sdio_oe <= 1'b0;
    end else begin
      if (sclk_rise) begin
        if (cnt < CNTW'(W)) begin
          addr_q <= addr_next;
          cnt    <= cnt + 1'b1;
          if (cnt == CNTW'(W-1) && sdi) begin
            rd_q <= 1'b1;
            tx_q <= rd_val;
          end
        end else begin
          if (cnt != FULL) cnt <= cnt + 1'b1;
          if (rd_q) begin
            if (waits != 2'd2) waits <= waits + 1'b1;
          end else
            data_q <= {sdi, data_q[W-1:1]};
        end
      end
      if (sclk_fall && rd_q && waits == 2'd2) begin
        if (sent != 4'(W)) begin
          sdio_out <= tx_q[0];
          tx_q     <= tx_q >> 1;
          sdio_oe  <= 1'b1;
          sent     <= sent + 1'b1;
        end else
          sdio_oe <= 1'b0;
      end
    end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) regs_flat[g*W +: W] <= '0;
      else if (commit && addr_q[5:0] == 6'(g)) regs_flat[g*W +: W] <= data_q;
  end

  p_regs_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sen_fall |=> $stable(regs_flat));
  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sen_s |=> !sdio_oe);
  p_drive_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdio_oe) |-> $past(sclk_fall));
  p_bit_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sdio_oe && !sclk_fall) |=> $stable(sdio_out));
  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sen_s && !sen_fall) |=> $stable(regs_flat));
endmodule

// File: tb/serial_reg_port_test.sv
module serial_reg_port_test;
  localparam int N = 11;
  localparam int H = 8;
  logic clk = 0, rst_n = 0, sclk = 0, sen = 0, sdi = 0;
  logic sdio_out, sdio_oe;
  logic [N*8-1:0] regs_flat;
  int checks = 0, failures = 0;
  bit done = 0;

  serial_reg_port uut (.clk(clk), .rst_n(rst_n), .sclk(sclk), .sen(sen),
    .sdio_in(sdi), .sdio_out(sdio_out), .sdio_oe(sdio_oe), .regs_flat(regs_flat));

  always #4 clk = ~clk;

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic pulse(input logic b);
    sdi = b; wait_clk(H); sclk = 1; wait_clk(H); sclk = 0;
  endtask

  task automatic send(input logic [31:0] v, input int n);
    for (int i = 0; i < n; i++) pulse(v[i]);
  endtask

  task automatic frame(input logic [7:0] a, input logic [31:0] d, input int nd);
    sen = 1; wait_clk(H);
    send({24'b0, a}, 8); send(d, nd);
    wait_clk(H); sen = 0; wait_clk(8);
  endtask

  task automatic read_reg(input logic [7:0] a, input string req, output logic [7:0] got);
    logic oe_ok = 1;
    sen = 1; wait_clk(H);
    send({24'b0, a}, 8);
    pulse(0); wait_clk(6);
    check({req, " oe low in wait"}, sdio_oe, 0);
    pulse(0);
    for (int i = 0; i < 8; i++) begin
      wait_clk(6);
      got[i] = sdio_out;
      oe_ok &= sdio_oe;
      if (i < 7) pulse(0);
    end
    check({req, " oe during data"}, oe_ok, 1);
    wait_clk(H); sen = 0; wait_clk(8);
  endtask

  function automatic logic [7:0] reg_of(input int i);
    return regs_flat[i*8 +: 8];
  endfunction

  task automatic t_reset;
    check("R1 regs", regs_flat == '0, 1);
    check("R1 oe", sdio_oe, 0);
  endtask

  task automatic t_write;
    sen = 1; wait_clk(H);
    send(32'h03, 8); send(32'hA5, 8); wait_clk(H);
    check("R9 before commit", reg_of(3), 8'h00);
    sen = 0; wait_clk(8);
    check("R2 reg3", reg_of(3), 8'hA5);
    frame(8'h41, 32'h3C, 8);
    check("R2 a6 ignored", reg_of(1), 8'h3C);
  endtask

  task automatic t_short;
    logic [N*8-1:0] snap = regs_flat;
    frame(8'h03, 32'hFF, 5);
    check("R3 short data", reg_of(3), 8'hA5);
    frame(8'h06, 32'h0, -8 + 8);
    check("R3 addr only", regs_flat == snap, 1);
  endtask

  task automatic t_overrun;
    frame(8'h02, 32'h5AC311, 24);
    check("R4 overrun", reg_of(2), 8'h5A);
  endtask

  task automatic t_idle;
    logic [N*8-1:0] snap = regs_flat;
    for (int i = 0; i < 5; i++) pulse(1);
    wait_clk(8);
    check("R5 idle toggles", regs_flat == snap, 1);
    frame(8'h04, 32'h81, 8);
    check("R5 clean frame", reg_of(4), 8'h81);
  endtask

  task automatic t_read;
    logic [7:0] g;
    read_reg(8'h83, "R6", g); check("R6 read reg3", g, 8'hA5);
    read_reg(8'h82, "R6", g); check("R6 read reg2", g, 8'h5A);
    read_reg(8'hC4, "R6", g); check("R6 read a6 set", g, 8'h81);
  endtask

  task automatic t_id;
    logic [7:0] g;
    logic [N*8-1:0] snap;
    read_reg(8'h8F, "R8", g); check("R8 id", g, 8'h03);
    snap = regs_flat;
    frame(8'h0F, 32'hFF, 8);
    read_reg(8'h8F, "R8", g); check("R8 id after write", g, 8'h03);
    frame(8'h0C, 32'hFF, 8);
    check("R8 unmapped write", regs_flat == snap, 1);
    read_reg(8'h8C, "R8", g); check("R8 unmapped read", g, 8'h00);
  endtask

  task automatic t_abort;
    logic [N*8-1:0] snap = regs_flat;
    sen = 1; wait_clk(H);
    send(32'h83, 8); pulse(0); pulse(0);
    wait_clk(6);
    check("R7 driving before abort", sdio_oe, 1);
    pulse(0); pulse(0);
    sen = 0; wait_clk(6);
    check("R7 released", sdio_oe, 0);
    check("R7 regs unchanged", regs_flat == snap, 1);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    wait_clk(5); rst_n = 1; wait_clk(5);
    t_reset; t_write; t_short; t_overrun; t_idle; t_read; t_id; t_abort;
    finish_run;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run;
  end
endmodule